// File: doc/BRIEF.md
# Dual-Range Monitor Scaler

This block sits behind the converter of one monitor channel, most often a receive-signal-strength input. It turns each raw sample into a calibrated 16-bit reading and picks one of two calibration ranges from the data itself.

- **Low range.** Used while the signal is small. The scaled product is right-shifted by a fixed extra amount, which gives finer resolution. This range has its own gain and offset.
- **Normal range.** Used while the signal is large. It has no extra shift and uses a second gain and offset.

The range changes only when a sample leaves a band of ±hysteresis around a threshold, so a signal near the threshold does not flip the range on every sample.

A range decision made on one sample applies from the next valid sample onward. Each result is therefore scaled entirely with one calibration set, and a flag beside the result tells which set that was. Two configuration bits must both be set for automatic ranging. If either bit is clear, the channel acts as a plain monitor channel that always uses the normal-range set.

Top module: `dual_range_mon`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `res_vld`, `res` and `res_lo` are 0, and the range state is the normal range.
- R2: `res_vld` is high exactly one clock cycle after each cycle in which `samp_vld` is high, and low otherwise.
- R3: In the normal range, `res = min(65535, ((samp * gain_hi) >> 15) + off_hi)`.
- R4: In the low range, `res = min(65535, ((samp * gain_lo) >> (15 + SHIFT)) + off_lo)`, with SHIFT = 3 by default.
- R5: A sum above 65535 saturates `res` to 65535 in either range.
- R6: From the normal range, the state moves to the low range only on a valid sample with `samp + hys < thr`. The triggering sample is still scaled with the normal set, and the following valid sample uses the low set.
- R7: From the low range, the state moves to the normal range only on a valid sample with `samp > thr + hys`. The triggering sample is still scaled with the low set, and the following valid sample uses the normal set.
- R8: Valid samples inside the band `thr - hys <= samp <= thr + hys`, the edges included, leave the range unchanged.
- R9: If `dr_en_a` or `dr_en_b` is 0, a sample is scaled with the normal set and gives `res_lo = 0`. The range state also returns to the normal range, so after re-enabling, the next in-band sample is scaled with the normal set.
- R10: `res_lo` is 1 exactly when the result beside it was scaled with the low set. `res` and `res_lo` hold their values in cycles after which no sample was valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | Sample strobe |
| samp | input | 16 | Raw unsigned conversion sample |
| dr_en_a | input | 1 | First auto-range enable bit |
| dr_en_b | input | 1 | Second auto-range enable bit |
| thr | input | 16 | Range switch threshold |
| hys | input | 16 | Hysteresis half-width |
| gain_hi | input | 16 | Normal-range gain, scaled by 2^-15 |
| off_hi | input | 16 | Normal-range offset |
| gain_lo | input | 16 | Low-range gain, scaled by 2^-15 |
| off_lo | input | 16 | Low-range offset |
| res_vld | output | 1 | Result strobe |
| res | output | 16 | Calibrated saturated result |
| res_lo | output | 1 | Result was scaled with the low-range set |

## Verification
The hardest situation to reach from the ports is a sample that triggers a range change, because it must still be scaled with the old set while its successor uses the new one. The stimulus reaches it by walking samples to both band edges and then one code past each edge. It then repeats the triggering value, so both sides of the switch produce distinct, predictable results.

Disabling auto-ranging while in the low range, and re-enabling it with an in-band sample, shows that the state was cleared. This is checked without looking inside the block.

// File: rtl/dual_range_mon.sv
module dual_range_mon #(
  parameter int DW    = 16,
  parameter int GW    = 16,
  parameter int FRAC  = 15,
  parameter int SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_vld,
  input  logic [DW-1:0] samp,
  input  logic          dr_en_a,
  input  logic          dr_en_b,
  input  logic [DW-1:0] thr,
  input  logic [DW-1:0] hys,
  input  logic [GW-1:0] gain_hi,
  input  logic [DW-1:0] off_hi,
  input  logic [GW-1:0] gain_lo,
  input  logic [DW-1:0] off_lo,
  output logic          res_vld,
  output logic [DW-1:0] res,
  output logic          res_lo
);
  localparam int PW = DW + GW;

  logic          rng_lo;
  logic          en, use_lo, go_lo, go_hi;
  logic [GW-1:0] g;
  logic [DW-1:0] o;
  logic [PW-1:0] prod, scaled;
  logic [PW:0]   sum;
  logic [DW-1:0] sat;

  assign en     = dr_en_a & dr_en_b;
  assign use_lo = en & rng_lo;
  assign g      = use_lo ? gain_lo : gain_hi;
  assign o      = use_lo ? off_lo : off_hi;
  assign prod   = {{GW{1'b0}}, samp} * {{DW{1'b0}}, g};
  assign scaled = use_lo ? (prod >> (FRAC + SHIFT)) : (prod >> FRAC);
  assign sum    = {1'b0, scaled} + {{(PW+1-DW){1'b0}}, o};
  assign sat    = (|sum[PW:DW]) ? {DW{1'b1}} : sum[DW-1:0];

  assign go_lo = ({1'b0, samp} + {1'b0, hys}) < {1'b0, thr};
  assign go_hi = {1'b0, samp} > ({1'b0, thr} + {1'b0, hys});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_lo  <= 1'b0;
      res_vld <= 1'b0;
      res     <= '0;
      res_lo  <= 1'b0;
    end else begin
      res_vld <= samp_vld;
      if (samp_vld) begin
        res    <= sat;
        res_lo <= use_lo;
      end
      if (!en)
        rng_lo <= 1'b0;
      else if (samp_vld)
        rng_lo <= rng_lo ? !go_hi : go_lo;
    end
  end
endmodule

module dual_range_mon_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          samp_vld,
  input logic [DW-1:0] samp,
  input logic          dr_en_a,
  input logic          dr_en_b,
  input logic [DW-1:0] thr,
  input logic [DW-1:0] hys,
  input logic          rng_lo,
  input logic          res_vld,
  input logic [DW-1:0] res,
  input logic          res_lo
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!res_vld && res == '0 && !res_lo && !rng_lo));

  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    samp_vld |=> res_vld);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_vld |=> !res_vld);

  a_r6_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rng_lo) |-> ($past(samp_vld) &&
      (({1'b0, $past(samp)} + {1'b0, $past(hys)}) < {1'b0, $past(thr)})));

  a_r7_leave_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rng_lo) |-> ($past(!(dr_en_a && dr_en_b)) || ($past(samp_vld) &&
      ({1'b0, $past(samp)} > ({1'b0, $past(thr)} + {1'b0, $past(hys)})))));

  a_r9_off_is_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_vld && !(dr_en_a && dr_en_b)) |=> !res_lo);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_vld |=> ($stable(res) && $stable(res_lo)));
endmodule

bind dual_range_mon dual_range_mon_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp(samp),
  .dr_en_a(dr_en_a), .dr_en_b(dr_en_b), .thr(thr), .hys(hys),
  .rng_lo(rng_lo), .res_vld(res_vld), .res(res), .res_lo(res_lo)
);

// File: tb/dual_range_mon_tb.sv
`timescale 1ns/1ps
module dual_range_mon_tb;
  localparam int SH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_vld = 1'b0;
  logic [15:0] samp = '0;
  logic        dr_en_a = 1'b1, dr_en_b = 1'b1;
  logic [15:0] thr = 16'd1000, hys = 16'd50;
  logic [15:0] gain_hi = 16'd32768, off_hi = 16'd10;
  logic [15:0] gain_lo = 16'd65535, off_lo = 16'd5;
  logic        res_vld, res_lo;
  logic [15:0] res;

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit m_lo = 1'b0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dual_range_mon #(.SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp(samp),
    .dr_en_a(dr_en_a), .dr_en_b(dr_en_b), .thr(thr), .hys(hys),
    .gain_hi(gain_hi), .off_hi(off_hi), .gain_lo(gain_lo), .off_lo(off_lo),
    .res_vld(res_vld), .res(res), .res_lo(res_lo)
  );

  task automatic check(string tag, bit ok, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] s, input string tag);
    bit en, ul;
    longint p, sc, sm;
    @(negedge clk);
    en = dr_en_a && dr_en_b;
    ul = en && m_lo;
    p  = longint'(s) * longint'(ul ? gain_lo : gain_hi);
    sc = ul ? (p >> (15 + SH)) : (p >> 15);
    sm = sc + longint'(ul ? off_lo : off_hi);
    if (sm > 65535) sm = 65535;
    exp_q.push_back({ul, sm[15:0]});
    tag_q.push_back(tag);
    if (!en) m_lo = 1'b0;
    else if (m_lo) m_lo = !(int'(s) > int'(thr) + int'(hys));
    else m_lo = (int'(s) + int'(hys)) < int'(thr);
    samp = s;
    samp_vld = 1'b1;
    @(negedge clk);
    samp_vld = 1'b0;
  endtask

  task automatic set_en(bit a, bit b);
    @(negedge clk);
    dr_en_a = a;
    dr_en_b = b;
    if (!(a && b)) m_lo = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected result", 1'b0, 1, 0);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {res_lo, res} == e, {res_lo, res}, e);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset vld", res_vld == 1'b0, res_vld, 0);
    check("R1 reset res", res == 16'd0, res, 0);
    check("R1 reset flag", res_lo == 1'b0, res_lo, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle vld", res_vld == 1'b0, res_vld, 0);

    send(16'd2000, "R3 normal large");
    send(16'd960,  "R8 inside band low side");
    send(16'd950,  "R8 exactly at lower edge");
    send(16'd949,  "R6 trigger still normal");
    send(16'd949,  "R6 next uses low set R4");
    send(16'd1000, "R8 in band stays low");
    send(16'd1050, "R8 exactly at upper edge stays low");
    send(16'd1051, "R7 trigger still low");
    send(16'd1051, "R7 next uses normal set");
    send(16'd960,  "R8 band from normal stays normal");

    repeat (3) begin
      @(negedge clk);
      check("R2 idle no strobe", res_vld == 1'b0, res_vld, 0);
      check("R10 result held", res == 16'd970, res, 970);
    end

    send(16'd100, "R6 enter low again");
    send(16'd100, "R4 low small");
    set_en(1'b1, 1'b0);
    send(16'd100, "R9 disabled uses normal set");
    set_en(1'b1, 1'b1);
    send(16'd1020, "R9 state cleared after re-enable");

    off_hi = 16'd65000;
    send(16'd65535, "R5 saturate normal");
    off_hi = 16'd10;
    send(16'd10, "R6 go low for saturation");
    off_lo = 16'd65530;
    send(16'd5000, "R5 saturate low");
    set_en(1'b0, 1'b1);
    send(16'd10, "R9 other bit clear");

    repeat (3) @(negedge clk);
    check("R2 all results seen", exp_q.size() == 0, exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule